// File: doc/BRIEF.md
# Masked Per-Port Event Counter

This block keeps a 16-bit event counter for each network port. Each port drives a vector of single-cycle event strobes. A shared control register holds one enable bit per event type and two mode bits. The enable bits decide which strobes advance the counters. The mode bits decide whether a full counter stops at its maximum or rolls over, and whether reading a counter also clears it.

Software reaches the control register and the counters through a simple register port. It has a write strobe, a read strobe, an address and write data. Read data is registered and is valid in the cycle after the read strobe. A collision that falls outside the collision window is reported on its own strobe together with the strobe of its direction. It therefore advances a counter by two when both the window category and the matching direction category are enabled.

Top module: `port_event_counter`

## Requirements
- R1: After a synchronous reset every counter is 0000h, the control register is 0 and the read data output is 0.
- R2: With the freeze bit (control bit 10) clear, a counter at FFFFh that takes an increment rolls over: +1 gives 0000h and +2 gives 0001h.
- R3: With the freeze bit set, a counter stops at FFFFh. A counter at FFFFh holds, and a +2 from FFFEh gives FFFFh.
- R4: With the clear-on-read bit (control bit 11) set, reading a counter returns its value and leaves the counter at 0000h. With the bit clear, a read leaves the counter unchanged.
- R5: When a clearing read and a counted event hit the same port in the same cycle, the read returns the old value and the counter becomes the increment of that event (1 or 2).
- R6: Event bit 0 is the transmit collision strobe and enable bit 0 counts it. Event bit 1 is the receive collision strobe and enable bit 1 counts it. Each enable counts only its own direction.
- R7: Event bit 2 flags a collision outside the window and is strobed together with bit 0 or bit 1. Enable bit 2 counts it with +1 by itself. When the matching direction bit is also enabled, the counter advances by +2 in one cycle.
- R8: Event bits 3 to 9 (jabber, elasticity buffer error, lock error, missing start delimiter, short event, partition, bad link) are each counted through the enable bit of the same index. Any number of them together in one cycle add 1.
- R9: Strobes whose enable bit is 0 leave the counters unchanged.
- R10: Control bits 15 to 12 are reserved. They read back as 0 and have no effect.
- R11: A write to address 1+p loads counter p with the write data. An event on that port in the same cycle is discarded.
- R12: An event on one port changes only the counter of that port.
- R13: Address 0 is the control register and address 1+p is counter p. Reads of other addresses return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | NUM_PORTS*10 | Event strobes, port p at bits [p*10+9:p*10] |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Registered read data, valid the cycle after reg_rd |

## Verification
The counting rule is driven with single direction strobes under each direction enable alone and under both together. This separates per-direction selection from "any collision". Window collisions are sent with the window enable alone and then with a matching direction enable. This shows the +1 and +2 paths apart. Groups of non-collision strobes arriving in one cycle confirm that they add one and not one each. Preloaded counters near FFFFh under both full-counter modes, and reads that coincide with events, expose wrap, saturation and a lost or doubled increment.

// File: rtl/pevc_pkg.sv
package pevc_pkg;
    localparam int NUM_EVT    = 10;
    localparam int EV_TX      = 0;
    localparam int EV_RX      = 1;
    localparam int EV_LATE    = 2;
    localparam int EV_MISC_LO = 3;
    localparam int CTL_USED   = 12;

    typedef struct packed {
        logic                clr_rd;
        logic                freeze;
        logic [NUM_EVT-1:0]  mask;
    } ctl_t;
endpackage

// File: rtl/pevc_inc.sv
module pevc_inc
    import pevc_pkg::*;
(
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [NUM_EVT-1:0] mask_i,
    output logic [1:0]         inc_o
);
    logic coll_hit;
    logic misc_hit;
    logic late_hit;

    always_comb begin
        coll_hit = (evt_i[EV_TX] & mask_i[EV_TX]) | (evt_i[EV_RX] & mask_i[EV_RX]);
        misc_hit = |(evt_i[NUM_EVT-1:EV_MISC_LO] & mask_i[NUM_EVT-1:EV_MISC_LO]);
        late_hit = evt_i[EV_LATE] & mask_i[EV_LATE];
        inc_o    = {1'b0, coll_hit | misc_hit} + {1'b0, late_hit};
    end

    // R7: a matched window collision plus a matched direction yields two
    always_comb begin
        if (late_hit && coll_hit) begin
            assert_late_double_R7: assert (inc_o == 2'd2);
        end
        if (!(late_hit || coll_hit || misc_hit)) begin
            assert_masked_zero_R9: assert (inc_o == 2'd0);
        end
    end
endmodule

// File: rtl/pevc_cnt.sv
module pevc_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       inc_i,
    input  logic             clr_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             freeze_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0] base;
    logic [CNT_W:0]   sum;

    always_comb begin
        st_d = st_q;
        base = clr_i ? '0 : st_q.cnt;
        sum  = {1'b0, base} + {{(CNT_W-1){1'b0}}, inc_i};
        if (load_i) begin
            st_d.cnt = load_val_i;
        end else if (freeze_i) begin
            if (!clr_i && st_q.cnt == FULL) begin
                st_d.cnt = FULL;
            end else begin
                st_d.cnt = sum[CNT_W] ? FULL : sum[CNT_W-1:0];
            end
        end else begin
            st_d.cnt = sum[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    assert_freeze_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (freeze_i && st_q.cnt == FULL && !clr_i && !load_i) |=> (st_q.cnt == FULL));

    assert_clear_keeps_event_R5: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !load_i) |=> (st_q.cnt == CNT_W'($past(inc_i))));

    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (inc_i == 2'd0 && !clr_i && !load_i) |=> $stable(st_q.cnt));

    assert_load_wins_R11: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (st_q.cnt == $past(load_val_i)));
endmodule

// File: rtl/pevc_regs.sv
module pevc_regs
    import pevc_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int CNT_W     = 16,
    parameter int ADDR_W    = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_i,
    input  logic                       rd_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [CNT_W-1:0]           wdata_i,
    input  logic [NUM_PORTS*CNT_W-1:0] cnt_i,
    output ctl_t                       ctl_o,
    output logic [NUM_PORTS-1:0]       clr_o,
    output logic [NUM_PORTS-1:0]       load_o,
    output logic [CNT_W-1:0]           rdata_o
);
    localparam int CTL_W = $bits(ctl_t);

    typedef struct packed {
        ctl_t             ctl;
        logic [CNT_W-1:0] rdata;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0] rd_val;

    always_comb begin
        rd_val = '0;
        if (addr_i == '0) rd_val = CNT_W'(st_q.ctl);
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (addr_i == ADDR_W'(p + 1)) rd_val = cnt_i[p*CNT_W +: CNT_W];
        end
    end

    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            clr_o[p]  = rd_i && st_q.ctl.clr_rd && (addr_i == ADDR_W'(p + 1));
            load_o[p] = wr_i && (addr_i == ADDR_W'(p + 1));
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr_i && addr_i == '0) st_d.ctl = ctl_t'(wdata_i[CTL_W-1:0]);
        if (rd_i)                 st_d.rdata = rd_val;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ctl_o   = st_q.ctl;
    assign rdata_o = st_q.rdata;

    assert_ctl_write_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_i && addr_i == '0) |=> (CNT_W'(st_q.ctl) == CNT_W'($past(wdata_i[CTL_W-1:0]))));

    assert_ctl_read_R13: assert property (@(posedge clk) disable iff (rst)
        (rd_i && addr_i == '0) |=> (rdata_o == CNT_W'($past(st_q.ctl))));

    assert_one_clear_R4: assert property (@(posedge clk) disable iff (rst)
        $countones(clr_o) <= 1);
endmodule

// File: rtl/port_event_counter.sv
module port_event_counter
    import pevc_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int CNT_W     = 16,
    parameter int ADDR_W    = $clog2(NUM_PORTS + 2)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_PORTS*NUM_EVT-1:0] evt_i,
    input  logic                         reg_wr,
    input  logic                         reg_rd,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic [CNT_W-1:0]             reg_wdata,
    output logic [CNT_W-1:0]             reg_rdata
);
    ctl_t                       ctl;
    logic [NUM_PORTS-1:0]       clr;
    logic [NUM_PORTS-1:0]       load;
    logic [NUM_PORTS*CNT_W-1:0] cnt_flat;

    pevc_regs #(
        .NUM_PORTS (NUM_PORTS),
        .CNT_W     (CNT_W),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (reg_wr),
        .rd_i    (reg_rd),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .cnt_i   (cnt_flat),
        .ctl_o   (ctl),
        .clr_o   (clr),
        .load_o  (load),
        .rdata_o (reg_rdata)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [1:0] inc;

        pevc_inc u_inc (
            .evt_i  (evt_i[p*NUM_EVT +: NUM_EVT]),
            .mask_i (ctl.mask),
            .inc_o  (inc)
        );

        pevc_cnt #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk        (clk),
            .rst        (rst),
            .inc_i      (inc),
            .clr_i      (clr[p]),
            .load_i     (load[p]),
            .load_val_i (reg_wdata),
            .freeze_i   (ctl.freeze),
            .cnt_o      (cnt_flat[p*CNT_W +: CNT_W])
        );
    end

    assert_reset_rdata_R1: assert property (@(posedge clk)
        rst |=> (reg_rdata == '0));
endmodule

// File: tb/test_port_event_counter.sv
module test_port_event_counter;
    localparam int NP = 4;
    localparam int NE = 10;
    localparam int CW = 16;
    localparam int AW = $clog2(NP + 2);
    localparam logic [15:0] FRZ = 16'h0400;
    localparam logic [15:0] CLR = 16'h0800;

    logic clk = 0;
    logic rst = 1;
    logic [NP*NE-1:0] evt = '0;
    logic reg_wr = 0, reg_rd = 0;
    logic [AW-1:0] reg_addr = '0;
    logic [CW-1:0] reg_wdata = '0;
    logic [CW-1:0] reg_rdata;

    int n_chk = 0, n_fail = 0, cycles = 0;
    bit done = 0;

    port_event_counter #(.NUM_PORTS(NP), .CNT_W(CW), .ADDR_W(AW)) i_port_event_counter (
        .clk(clk), .rst(rst), .evt_i(evt), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always #2 clk = ~clk;

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: act=%0d cycles exp=<20000", cycles);
            finish_run();
        end
    end

    task automatic check(string req, logic [CW-1:0] act, logic [CW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [CW-1:0] d, logic [NE-1:0] ev = '0, int p = 0);
        @(negedge clk);
        reg_wr = 1; reg_addr = AW'(a); reg_wdata = d;
        evt[p*NE +: NE] = ev;
        @(negedge clk);
        reg_wr = 0; evt = '0;
    endtask

    task automatic rd(int a, output logic [CW-1:0] d, input logic [NE-1:0] ev = '0, input int p = 0);
        @(negedge clk);
        reg_rd = 1; reg_addr = AW'(a);
        evt[p*NE +: NE] = ev;
        @(negedge clk);
        reg_rd = 0; evt = '0;
        d = reg_rdata;
    endtask

    task automatic pulse(int p, logic [NE-1:0] ev);
        @(negedge clk);
        evt[p*NE +: NE] = ev;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic expect_cnt(string req, int p, logic [CW-1:0] exp);
        logic [CW-1:0] v;
        rd(p + 1, v);
        check(req, v, exp);
    endtask

    task automatic t_reset();
        logic [CW-1:0] v;
        check("R1 rdata", reg_rdata, '0);
        rd(0, v); check("R1 ctl", v, '0);
        for (int p = 0; p < NP; p++) expect_cnt("R1 cnt", p, '0);
    endtask

    task automatic t_direction();
        wr(0, 16'h0001);
        pulse(0, 10'h001); expect_cnt("R6 tx counted", 0, 1);
        pulse(0, 10'h002); expect_cnt("R6 rx ignored", 0, 1);
        wr(0, 16'h0002);
        pulse(0, 10'h002); expect_cnt("R6 rx counted", 0, 2);
        pulse(0, 10'h001); expect_cnt("R6 tx ignored", 0, 2);
        wr(0, 16'h0003);
        pulse(0, 10'h001); pulse(0, 10'h002);
        expect_cnt("R6 both", 0, 4);
        expect_cnt("R4 no clear", 0, 4);
    endtask

    task automatic t_late();
        wr(1, 16'h0000);
        wr(0, 16'h0004);
        pulse(0, 10'h005); expect_cnt("R7 window alone", 0, 1);
        pulse(0, 10'h001); expect_cnt("R7 plain tx ignored", 0, 1);
        wr(0, 16'h0005);
        pulse(0, 10'h005); expect_cnt("R7 double tx", 0, 3);
        wr(0, 16'h0007);
        pulse(0, 10'h006); expect_cnt("R7 double rx", 0, 5);
    endtask

    task automatic t_misc();
        wr(2, 16'h0000);
        wr(0, 16'h03F8);
        for (int b = 3; b < NE; b++) pulse(1, NE'(1) << b);
        expect_cnt("R8 each", 1, 7);
        pulse(1, 10'h3F8); expect_cnt("R8 group adds one", 1, 8);
        pulse(1, 10'h007); expect_cnt("R9 collisions masked", 1, 8);
        wr(0, 16'h0000);
        pulse(1, 10'h3FF); expect_cnt("R9 all masked", 1, 8);
    endtask

    task automatic t_wrap();
        wr(0, 16'h0008);
        wr(2, 16'hFFFE);
        pulse(1, 10'h008); expect_cnt("R2 to full", 1, 16'hFFFF);
        pulse(1, 10'h008); expect_cnt("R2 wrap", 1, 16'h0000);
        wr(0, 16'h0005);
        wr(2, 16'hFFFF);
        pulse(1, 10'h005); expect_cnt("R2 double wrap", 1, 16'h0001);
    endtask

    task automatic t_freeze();
        wr(0, FRZ | 16'h000D);
        wr(3, 16'hFFFE);
        pulse(2, 10'h005); expect_cnt("R3 double saturates", 2, 16'hFFFF);
        pulse(2, 10'h008); expect_cnt("R3 hold", 2, 16'hFFFF);
    endtask

    task automatic t_clear_read();
        logic [CW-1:0] v;
        wr(3, 16'h0005);
        wr(0, CLR | 16'h0008);
        rd(3, v); check("R4 read value", v, 16'h0005);
        rd(3, v); check("R4 cleared", v, 16'h0000);
        wr(3, 16'h0007);
        wr(0, CLR | 16'h0005);
        rd(3, v, 10'h005, 2); check("R5 old value", v, 16'h0007);
        rd(3, v); check("R5 event kept", v, 16'h0002);
        wr(0, 16'h0000);
    endtask

    task automatic t_load();
        wr(0, 16'h0008);
        wr(4, 16'h1234, 10'h008, 3);
        expect_cnt("R11 load wins", 3, 16'h1234);
    endtask

    task automatic t_reserved();
        logic [CW-1:0] v;
        wr(0, 16'hF008);
        rd(0, v); check("R10 reserved zero", v, 16'h0008);
        wr(1, 16'h0000);
        pulse(0, 10'h008); expect_cnt("R10 no effect", 0, 1);
    endtask

    task automatic t_addr();
        logic [CW-1:0] v;
        rd(NP + 1, v); check("R13 unused reads zero", v, '0);
        wr((1 << AW) - 1, 16'h0BFF);
        rd(0, v); check("R13 unused write ctl", v, 16'h0008);
        expect_cnt("R13 unused write cnt", 0, 1);
    endtask

    task automatic t_ports();
        wr(0, 16'h0008);
        for (int p = 0; p < NP; p++) wr(p + 1, 16'h0010);
        pulse(3, 10'h008);
        for (int p = 0; p < NP - 1; p++) expect_cnt("R12 other port", p, 16'h0010);
        expect_cnt("R12 own port", 3, 16'h0011);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_direction();
        t_late();
        t_misc();
        t_wrap();
        t_freeze();
        t_clear_read();
        t_load();
        t_reserved();
        t_addr();
        t_ports();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule